// File: doc/BRIEF.md
# Serial Control Register Port

This block is a four-wire serial slave that gives a host access to a small bank of converter control registers and to a set of peak-level values. The host frames each transfer with an active-low select line and clocks exactly sixteen bits, most significant first, on a bit clock. That bit clock has no fixed relation to the system clock or to the audio frame clock. The host drives data on the serial input. The block answers on a serial output, which floats whenever the select line is high.

All serial pins are resynchronised into the system clock domain and sampled there. In that domain a completed write frame updates one control register, and a read frame places the addressed value on the output within the same frame. An active-low power-down/reset input returns the bank to its default contents. After release, a memory-clear phase runs for a fixed number of frame-clock periods. During that phase the block reports busy, drops host writes and records the drop in a sticky error flag.

Top module: `serctl_port`

## Requirements
- R1: A frame word is sent most significant bit first. Bits 15:12 hold the register address, bit 11 is 1 for a read and 0 for a write, bit 10 is reserved, and bits 9:0 hold the data.
- R2: `sdi` is sampled on rising `sck` edges and `sdo` changes only after falling `sck` edges. `sdo` is high-impedance while `sel_n` is high and driven while it is low, with 0 on every slot that does not carry read data.
- R3: A frame takes effect only if exactly 16 rising `sck` edges occur between the fall and the rise of `sel_n`. A frame with any other count changes nothing.
- R4: A write frame to address 0 to NREG-1 (default 0 to 7) loads bits 9:0 into that register. The register appears on `cfg_flat[10*a +: 10]` on the fourth system clock edge after the rise of `sel_n` is seen. Registers change at no other time except reset.
- R5: Write frames to addresses NREG and above, including the peak addresses, leave every register unchanged.
- R6: In a read frame the slot of bit 10 carries 0 and slots 9..0 carry the addressed value, MSB first. Addresses below NREG return the register. Addresses PEAK_BASE+k (default 12 to 15) return `peak_flat[10*k +: 10]`. All other addresses return 0.
- R7: While `pdn_rst_n` is low, every register holds CFG_RESET (default 0x200), `busy` is 1, `wr_err` is 0 and `sdo` floats.
- R8: After reset release, `busy` stays 1 until CLR_FRAMES (default 20) rising edges of `lrclk` have been seen, then drops and stays 0 until the next reset.
- R9: A write frame accepted while `busy` is 1 changes no register and sets `wr_err`, which stays 1 until reset. Read frames work normally while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| pdn_rst_n | input | 1 | Power-down/reset, active low, asynchronous |
| lrclk | input | 1 | Frame clock, asynchronous, counted for the clear phase |
| sck | input | 1 | Serial bit clock, idle low |
| sel_n | input | 1 | Frame select, active low |
| sdi | input | 1 | Serial data from host |
| sdo | output | 1 | Serial data to host, high-impedance when deselected |
| peak_flat | input | NPEAK*10 | Peak-level values, 10 bits each |
| cfg_flat | output | NREG*10 | Control register contents, 10 bits each |
| busy | output | 1 | Post-reset clear phase in progress |
| wr_err | output | 1 | Sticky flag: a write was dropped during the clear phase |

## Verification
The hardest state to reach from the ports is a write that lands inside the clear phase. That phase ends only when the frame clock has counted out, and the frame clock runs freely. The stimulus therefore issues a write, and then a read, as soon as reset is released. These frames finish long before the twentieth frame-clock edge. The stimulus then waits for the clear phase to end before any normal traffic. The reference model follows the frame clock through its own queue, so the exact cycle in which `busy` drops is compared on every clock, as are the frames cut short or run one bit too long.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 10;
    localparam int CNT_W  = 5;
    localparam int HDR_W  = ADDR_W + 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              rnw;
        logic [DATA_W-1:0] data;
    } frame_t;
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int         W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic [1:0] pipe_d, pipe_q;

        always_comb begin
            pipe_d = {pipe_q[0], async_i[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {2{RST_VAL[g]}};
            else        pipe_q <= pipe_d;
        end

        assign sync_o[g] = pipe_q[1];
    end
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift
    import serctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck_s,
    input  logic              sel_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              frame_vld,
    output frame_t            frame,
    output logic              out_bit
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] HDR_CNT  = CNT_W'(HDR_W);

    typedef struct packed {
        logic              sck_p;
        logic              sel_p;
        logic [CNT_W-1:0]  cnt;
        logic [WORD_W-1:0] shin;
        logic [DATA_W:0]   shout;
        logic              vld;
        frame_t            word;
    } sh_state_t;

    sh_state_t d, q;
    logic      sck_rise, sck_fall;

    always_comb begin
        d        = q;
        d.vld    = 1'b0;
        d.sck_p  = sck_s;
        d.sel_p  = sel_s;
        sck_rise = sck_s & ~q.sck_p;
        sck_fall = ~sck_s & q.sck_p;
        if (sel_s) begin
            d.cnt   = '0;
            d.shout = '0;
            if (!q.sel_p && q.cnt == FULL_CNT) begin
                d.vld       = 1'b1;
                d.word.addr = q.shin[WORD_W-1 -: ADDR_W];
                d.word.rnw  = q.shin[DATA_W+1];
                d.word.data = q.shin[DATA_W-1:0];
            end
        end else begin
            if (sck_rise) begin
                d.shin = {q.shin[WORD_W-2:0], sdi_s};
                if (q.cnt != '1) d.cnt = q.cnt + 1'b1;
            end
            if (sck_fall) begin
                if (q.cnt == HDR_CNT)
                    d.shout = q.shin[0] ? {1'b0, rd_data} : '0;
                else if (q.cnt > HDR_CNT)
                    d.shout = {q.shout[DATA_W-1:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.sel_p <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr   = q.shin[ADDR_W:1];
    assign frame_vld = q.vld;
    assign frame     = q.word;
    assign out_bit   = q.shout[DATA_W];

    AST_VLD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.vld |=> !q.vld); // R3
    AST_OUT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && q.sel_p) |-> (q.shout == '0)); // R2
endmodule

// File: rtl/serctl_bank.sv
module serctl_bank
    import serctl_pkg::*;
#(
    parameter int               NREG       = 8,
    parameter int               NPEAK      = 4,
    parameter int               PEAK_BASE  = 12,
    parameter int               CLR_FRAMES = 20,
    parameter logic [DATA_W-1:0] CFG_RESET = 10'h200
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lr_s,
    input  logic                    frame_vld,
    input  frame_t                  frame,
    input  logic [ADDR_W-1:0]       rd_addr,
    input  logic [NPEAK*DATA_W-1:0] peak_flat,
    output logic [NREG*DATA_W-1:0]  cfg_flat,
    output logic [DATA_W-1:0]       rd_data,
    output logic                    busy,
    output logic                    wr_err
);
    localparam int CLR_W = $clog2(CLR_FRAMES + 1);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] cfg;
        logic [CLR_W-1:0]            clr_cnt;
        logic                        busy;
        logic                        err;
        logic                        lr_p;
    } bank_state_t;

    bank_state_t d, q;

    always_comb begin
        d      = q;
        d.lr_p = lr_s;
        if (q.busy && lr_s && !q.lr_p) begin
            d.clr_cnt = q.clr_cnt + 1'b1;
            if (d.clr_cnt == CLR_W'(CLR_FRAMES)) d.busy = 1'b0;
        end
        if (frame_vld && !frame.rnw) begin
            if (q.busy) begin
                d.err = 1'b1;
            end else begin
                for (int i = 0; i < NREG; i++)
                    if (frame.addr == ADDR_W'(i)) d.cfg[i] = frame.data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NREG; i++)
            if (rd_addr == ADDR_W'(i)) rd_data = q.cfg[i];
        for (int k = 0; k < NPEAK; k++)
            if (rd_addr == ADDR_W'(PEAK_BASE + k)) rd_data = peak_flat[k*DATA_W +: DATA_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cfg     <= {NREG{CFG_RESET}};
            q.clr_cnt <= '0;
            q.busy    <= 1'b1;
            q.err     <= 1'b0;
            q.lr_p    <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign cfg_flat = q.cfg;
    assign busy     = q.busy;
    assign wr_err   = q.err;

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        q.err |=> q.err); // R9
    AST_BUSY_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |=> !q.busy); // R8
    AST_BUSY_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy && frame_vld && !frame.rnw) |=> $stable(q.cfg)); // R9
    AST_CFG_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_vld |=> $stable(q.cfg)); // R4
endmodule

// File: rtl/serctl_port.sv
module serctl_port
    import serctl_pkg::*;
#(
    parameter int               NREG       = 8,
    parameter int               NPEAK      = 4,
    parameter int               PEAK_BASE  = 12,
    parameter int               CLR_FRAMES = 20,
    parameter logic [DATA_W-1:0] CFG_RESET = 10'h200
) (
    input  logic                    clk,
    input  logic                    pdn_rst_n,
    input  logic                    lrclk,
    input  logic                    sck,
    input  logic                    sel_n,
    input  logic                    sdi,
    output logic                    sdo,
    input  logic [NPEAK*DATA_W-1:0] peak_flat,
    output logic [NREG*DATA_W-1:0]  cfg_flat,
    output logic                    busy,
    output logic                    wr_err
);
    logic [3:0]        pins_s;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              frame_vld;
    frame_t            frame;
    logic              out_bit;

    serctl_sync #(.W(4), .RST_VAL(4'b0010)) u_sync (
        .clk     (clk),
        .rst_n   (pdn_rst_n),
        .async_i ({lrclk, sdi, sel_n, sck}),
        .sync_o  (pins_s)
    );

    serctl_shift u_shift (
        .clk       (clk),
        .rst_n     (pdn_rst_n),
        .sck_s     (pins_s[0]),
        .sel_s     (pins_s[1]),
        .sdi_s     (pins_s[2]),
        .rd_data   (rd_data),
        .rd_addr   (rd_addr),
        .frame_vld (frame_vld),
        .frame     (frame),
        .out_bit   (out_bit)
    );

    serctl_bank #(
        .NREG(NREG), .NPEAK(NPEAK), .PEAK_BASE(PEAK_BASE),
        .CLR_FRAMES(CLR_FRAMES), .CFG_RESET(CFG_RESET)
    ) u_bank (
        .clk       (clk),
        .rst_n     (pdn_rst_n),
        .lr_s      (pins_s[3]),
        .frame_vld (frame_vld),
        .frame     (frame),
        .rd_addr   (rd_addr),
        .peak_flat (peak_flat),
        .cfg_flat  (cfg_flat),
        .rd_data   (rd_data),
        .busy      (busy),
        .wr_err    (wr_err)
    );

    assign sdo = sel_n ? 1'bz : out_bit;
endmodule

// File: tb/tb_serctl_port.sv
module tb_serctl_port;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        pdn_rst_n = 1'b0;
    logic        lrclk = 1'b0;
    logic        sck = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdi = 1'b0;
    wire         sdo;
    logic [39:0] peak_flat;
    logic [79:0] cfg_flat;
    logic        busy, wr_err;

    int n_chk = 0;
    int n_err = 0;

    logic [9:0] cfg_m [8];
    bit         busy_m = 1'b1;
    bit         err_m = 1'b0;
    bit         lrq [$];
    int         lr_cnt = 0;

    serctl_port dut (
        .clk(clk), .pdn_rst_n(pdn_rst_n), .lrclk(lrclk), .sck(sck), .sel_n(sel_n),
        .sdi(sdi), .sdo(sdo), .peak_flat(peak_flat), .cfg_flat(cfg_flat),
        .busy(busy), .wr_err(wr_err)
    );

    always #10 clk = ~clk;

    initial forever begin
        repeat (32) @(negedge clk);
        lrclk = ~lrclk;
    end

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [79:0] cfg_exp();
        logic [79:0] v;
        for (int i = 0; i < 8; i++) v[i*10 +: 10] = cfg_m[i];
        return v;
    endfunction

    function automatic logic [9:0] peak_of(input int k);
        return peak_flat[k*10 +: 10];
    endfunction

    // reference model of the clear phase: frame-clock history in a queue
    always @(posedge clk) begin
        if (!pdn_rst_n) begin
            lrq = '{1'b0, 1'b0, 1'b0, 1'b0};
            lr_cnt = 0;
            busy_m = 1'b1;
        end else begin
            lrq.push_front(lrclk);
            lrq = lrq[0:3];
            if (busy_m && lrq[2] && !lrq[3]) begin
                lr_cnt++;
                if (lr_cnt == 20) busy_m = 1'b0;
            end
        end
    end

    // compare on every clock
    always @(negedge clk) begin
        if (pdn_rst_n) begin
            chk("R4 cfg_flat", cfg_flat, cfg_exp());
            chk("R8 busy", {79'd0, busy}, {79'd0, busy_m});
            chk("R9 wr_err", {79'd0, wr_err}, {79'd0, err_m});
        end
    end

    task automatic wait_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xfer(input logic [15:0] w, input int nbits, output logic [9:0] got);
        got = '0;
        sel_n = 1'b0;
        wait_neg(H);
        for (int b = 0; b < nbits; b++) begin
            sdi = (b < 16) ? w[15-b] : 1'b0;
            wait_neg(H);
            if (b == 0) chk("R2 sdo driven low in frame", {79'd0, sdo}, 80'd0);
            if (b == 5 && w[11]) chk("R6 reserved slot", {79'd0, sdo}, 80'd0);
            if (b >= 6 && b < 16) got[15-b] = sdo;
            sck = 1'b1;
            wait_neg(H);
            sck = 1'b0;
        end
        wait_neg(H);
        sel_n = 1'b1;
        repeat (4) @(posedge clk);
        if (nbits == 16 && !w[11]) begin
            if (busy_m) err_m = 1'b1;
            else if (w[15:12] < 4'd8) cfg_m[w[15:12]] = w[9:0];
        end
        wait_neg(1);
        chk("R2 sdo floats when deselected", {79'd0, sdo}, {79'd0, 1'bz});
    endtask

    task automatic wr(input logic [3:0] a, input logic [9:0] v);
        logic [9:0] dummy;
        xfer({a, 1'b0, 1'b0, v}, 16, dummy);
    endtask

    task automatic rd_chk(input string tag, input logic [3:0] a, input logic [9:0] exp);
        logic [9:0] got;
        xfer({a, 1'b1, 11'd0}, 16, got);
        chk(tag, {70'd0, got}, {70'd0, exp});
    endtask

    task automatic do_reset();
        pdn_rst_n = 1'b0;
        for (int i = 0; i < 8; i++) cfg_m[i] = 10'h200;
        err_m = 1'b0;
        wait_neg(3);
        chk("R7 cfg defaults in reset", cfg_flat, {8{10'h200}});
        chk("R7 busy in reset", {79'd0, busy}, 80'd1);
        chk("R7 wr_err clear in reset", {79'd0, wr_err}, 80'd0);
        chk("R7 sdo floats in reset", {79'd0, sdo}, {79'd0, 1'bz});
        pdn_rst_n = 1'b1;
    endtask

    initial begin
        peak_flat = {10'h2AA, 10'h155, 10'h0F0, 10'h3A5};
        for (int i = 0; i < 8; i++) cfg_m[i] = 10'h200;
        wait_neg(2);
        do_reset();

        // writes and reads during the clear phase
        wr(4'd3, 10'h155);
        chk("R9 write dropped while busy", {70'd0, cfg_flat[30 +: 10]}, {70'd0, 10'h200});
        chk("R9 error flag set", {79'd0, wr_err}, 80'd1);
        rd_chk("R9 read of peak while busy (R6)", 4'd13, peak_of(1));
        rd_chk("R9 read of default register while busy", 4'd5, 10'h200);

        wait (!busy_m);
        wait_neg(2);
        chk("R8 clear phase length in frame edges", lr_cnt, 80'd20);

        // register writes with distinct patterns, read back
        for (int i = 0; i < 8; i++) wr(4'(i), 10'((i * 97 + 'h31) & 'h3FF));
        for (int i = 0; i < 8; i++) begin
            chk("R1 R4 write lands in field", {70'd0, cfg_flat[i*10 +: 10]},
                {70'd0, 10'((i * 97 + 'h31) & 'h3FF)});
            rd_chk("R6 register readback", 4'(i), 10'((i * 97 + 'h31) & 'h3FF));
        end
        wr(4'd6, 10'h3FF);
        rd_chk("R6 all-ones readback", 4'd6, 10'h3FF);
        wr(4'd6, 10'h001);
        rd_chk("R1 LSB-only readback", 4'd6, 10'h001);
        chk("R9 flag still sticky", {79'd0, wr_err}, 80'd1);

        // peak range and unmapped addresses
        for (int k = 0; k < 4; k++) rd_chk("R6 peak readback", 4'(12 + k), peak_of(k));
        wr(4'd12, 10'h000);
        rd_chk("R5 peak address not writable", 4'd12, peak_of(0));
        wr(4'd9, 10'h0CC);
        chk("R5 unmapped write ignored", cfg_flat, cfg_exp());
        rd_chk("R6 unmapped reads zero", 4'd9, 10'h000);

        // wrong-length frames
        begin
            logic [9:0] g;
            xfer({4'd2, 1'b0, 1'b0, 10'h0AB}, 15, g);
            chk("R3 short frame discarded", {70'd0, cfg_flat[20 +: 10]}, {70'd0, cfg_m[2]});
            xfer({4'd2, 1'b0, 1'b0, 10'h0AB}, 17, g);
            chk("R3 long frame discarded", {70'd0, cfg_flat[20 +: 10]}, {70'd0, cfg_m[2]});
        end

        // reset returns defaults and restarts the clear phase
        do_reset();
        wait_neg(2);
        chk("R8 busy again after reset", {79'd0, busy}, 80'd1);
        wait_neg(10);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule